// File: doc/BRIEF.md
# Fault Idle and Hiccup Restart Supervisor

This block sits between the digitized protection comparators of a switching regulator controller and its drive logic. It watches five logic levels: a bias-supply undervoltage flag, a conversion-supply undervoltage flag, an over-temperature flag, a short-circuit flag and a reference-ready flag. Each passes through a two-flop synchronizer. When any of the four fault flags is seen while the converter runs, a set-dominant fault latch forces an idle state. The gate drivers are turned off, a discharge request pulls the soft-start and compensation nodes low, and the run enable drops. All of this happens at once.

Idle lasts at least a fixed timeout, which is set as a count of system clocks. The typical value is about 100 ms. Fault activity during the timeout neither shortens it nor restarts it. When the timeout expires, the supervisor waits until both supply flags and the thermal flag are clear and the reference is ready, and then it restarts. A short-circuit fault clears itself once it has latched, so it never blocks a restart. If the short persists, the converter retries once in every timeout period: it runs for one clock, detects the short again and goes back to idle.

States: `ST_HOLD` is idle with the timeout expired, waiting for faults to clear. This is the reset state. `ST_WAIT` is idle while the timeout counts. `ST_RUN` is normal operation. Transitions: `HOLD->RUN` when the persistent faults are clear and the reference is ready. `RUN->WAIT` on any synchronized fault, with the timer loaded. `WAIT->HOLD` when the timer has expired. Any other condition keeps the current state.

Top module: `hiccup_supervisor`

## Requirements
- R1: After reset the block is in `ST_HOLD`: drv_off_o=1, discharge_o=1, run_en_o=0. With all faults clear and ref_ready_i=1, run_en_o rises at the third clock edge after reset release.
- R2: While running, a fault level on any of bias_uv_i, conv_uv_i, over_temp_i or short_i (active high) drops run_en_o and raises drv_off_o at the third rising edge after the input changes.
- R3: Once idle is entered from running, drv_off_o stays high for at least TIMEOUT_CYCLES clocks, even if the fault has already gone. With the faults gone, run_en_o returns TIMEOUT_CYCLES+1 edges after idle was entered.
- R4: After the timeout, the block stays idle while bias_uv_i, conv_uv_i or over_temp_i is high. It restarts at the third edge after the last of them clears.
- R5: A persistent short_i does not block a restart. run_en_o is high for exactly one clock out of every TIMEOUT_CYCLES+2. When the short is removed, the next restart sticks.
- R6: With ref_ready_i low, no restart occurs. It restarts at the third edge after ref_ready_i rises.
- R7: A fault pulse that arrives during the timeout does not extend the timeout.
- R8: drv_off_o and discharge_o are always equal, and run_en_o is always their inverse.
- R9: A fault input that is high for a single clock, and so is sampled by one edge, is latched and causes a full idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_uv_i | input | 1 | Bias-supply undervoltage, 1 = fault |
| conv_uv_i | input | 1 | Conversion-supply undervoltage, 1 = fault |
| over_temp_i | input | 1 | Over-temperature, 1 = fault |
| short_i | input | 1 | Output short circuit, 1 = fault |
| ref_ready_i | input | 1 | Reference ready, 1 = ready |
| drv_off_o | output | 1 | Gate drivers forced off |
| discharge_o | output | 1 | Pull soft-start and compensation low |
| run_en_o | output | 1 | Converter run enable |

## Verification
Every input takes two synchronizer edges and one state-register edge, so any result of an input change shows up at the third rising edge after the change. A timeout entered at edge E ends with the return to `ST_HOLD` at E+TIMEOUT_CYCLES, and a clean restart follows at the next edge. The bench counts rising edges from reset release, changes inputs just after a falling edge, and queues each expected output level tagged with the absolute edge count at which it is due. A falling-edge monitor compares each item exactly at that count, covering both the last cycle before a change and the first cycle after it.

// File: rtl/hiccup_sup_pkg.sv
package hiccup_sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } sup_state_e;

    localparam int N_MON      = 5;
    localparam int IDX_BIAS   = 0;
    localparam int IDX_CONV   = 1;
    localparam int IDX_TEMP   = 2;
    localparam int IDX_SHORT  = 3;
    localparam int IDX_REFOK  = 4;

    // Safe reset levels: faults asserted, reference not ready
    localparam logic [N_MON-1:0] MON_RESET = 5'b0_1111;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int                WIDTH    = 1,
    parameter logic [WIDTH-1:0]  RST_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1;
        logic stage2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL[g];
                stage2 <= RST_VAL[g];
            end else begin
                stage1 <= async_i[g];
                stage2 <= stage1;
            end
        end

        assign sync_o[g] = stage2;
    end

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);

    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LOAD_VAL = W'(CYCLES - 1);

    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load_i) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done_o = (remain == '0);

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
    import hiccup_sup_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bias_uv_i,
    input  logic conv_uv_i,
    input  logic over_temp_i,
    input  logic short_i,
    input  logic ref_ready_i,
    output logic drv_off_o,
    output logic discharge_o,
    output logic run_en_o
);

    logic [N_MON-1:0] mon_raw;
    logic [N_MON-1:0] mon_s;
    logic             any_fault;
    logic             persist_fault;
    logic             timer_load;
    logic             timer_done;
    sup_state_e       state_q;
    sup_state_e       state_d;

    assign mon_raw[IDX_BIAS]  = bias_uv_i;
    assign mon_raw[IDX_CONV]  = conv_uv_i;
    assign mon_raw[IDX_TEMP]  = over_temp_i;
    assign mon_raw[IDX_SHORT] = short_i;
    assign mon_raw[IDX_REFOK] = ref_ready_i;

    level_sync #(
        .WIDTH   (N_MON),
        .RST_VAL (MON_RESET)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mon_raw),
        .sync_o  (mon_s)
    );

    assign persist_fault = mon_s[IDX_BIAS] | mon_s[IDX_CONV] | mon_s[IDX_TEMP];
    assign any_fault     = persist_fault | mon_s[IDX_SHORT];

    idle_timer #(
        .CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .done_o (timer_done)
    );

    // Next-state logic; the fault latch is the set-dominant idle condition
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (any_fault) begin
                    state_d    = ST_WAIT;
                    timer_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (timer_done) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                // short-circuit is self-clearing: not part of the restart gate
                if (!persist_fault && mon_s[IDX_REFOK]) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_en_o    = 1'b0;
        drv_off_o   = 1'b1;
        discharge_o = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                run_en_o    = 1'b1;
                drv_off_o   = 1'b0;
                discharge_o = 1'b0;
            end
            ST_WAIT, ST_HOLD: begin
                run_en_o    = 1'b0;
                drv_off_o   = 1'b1;
                discharge_o = 1'b1;
            end
            default: begin
                run_en_o    = 1'b0;
                drv_off_o   = 1'b1;
                discharge_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk #(
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic bias_uv_i,
    input logic conv_uv_i,
    input logic over_temp_i,
    input logic short_i,
    input logic ref_ready_i,
    input logic drv_off_o,
    input logic discharge_o,
    input logic run_en_o
);

    logic [31:0] idle_cnt;
    logic        been_run;
    logic        raw_any;
    logic        raw_persist;

    assign raw_persist = bias_uv_i | conv_uv_i | over_temp_i;
    assign raw_any     = raw_persist | short_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            been_run <= 1'b0;
        end else begin
            if (run_en_o) begin
                idle_cnt <= '0;
                been_run <= 1'b1;
            end else if (idle_cnt != 32'hFFFF_FFFF) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    // R8: output coherence
    a_r8_outputs_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_off_o == discharge_o) && (run_en_o != drv_off_o));

    // R2: a fault seen while running ends the run
    a_r2_fault_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && $past(raw_any, 2)) |=> !run_en_o);

    // R3: idle lasts at least the timeout
    a_r3_min_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drv_off_o) && been_run) |-> (idle_cnt >= TIMEOUT_CYCLES));

    // R4: persistent faults block a restart
    a_r4_persist_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_o && $past(raw_persist, 2)) |=> !run_en_o);

    // R6: reference not ready blocks a restart
    a_r6_ref_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_o && !$past(ref_ready_i, 2)) |=> !run_en_o);

endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bias_uv_i   (bias_uv_i),
    .conv_uv_i   (conv_uv_i),
    .over_temp_i (over_temp_i),
    .short_i     (short_i),
    .ref_ready_i (ref_ready_i),
    .drv_off_o   (drv_off_o),
    .discharge_o (discharge_o),
    .run_en_o    (run_en_o)
);

// File: tb/hiccup_supervisor_bench.sv
module hiccup_supervisor_bench;

    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bias_uv = 1'b0;
    logic conv_uv = 1'b0;
    logic over_temp = 1'b0;
    logic short_f = 1'b0;
    logic ref_ready = 1'b1;
    logic drv_off;
    logic discharge;
    logic run_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit reported = 1'b0;

    typedef struct {
        int    at;
        logic  run;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    hiccup_supervisor #(.TIMEOUT_CYCLES(T)) u_hiccup_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .bias_uv_i   (bias_uv),
        .conv_uv_i   (conv_uv),
        .over_temp_i (over_temp),
        .short_i     (short_f),
        .ref_ready_i (ref_ready),
        .drv_off_o   (drv_off),
        .discharge_o (discharge),
        .run_en_o    (run_en)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic expect_run(input int at, input logic run, input string tag);
        exp_t e;
        e.at = at;
        e.run = run;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
        #1;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pop and compare each expected item at its edge count
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (run_en !== e.run || drv_off !== !e.run || discharge !== !e.run) begin
                    errors++;
                    $display("FAIL %s cyc=%0d run=%b drv_off=%b dis=%b expected run=%b drv_off=%b dis=%b",
                             e.tag, cyc, run_en, drv_off, discharge, e.run, !e.run, !e.run);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state, then clean start three edges later
        expect_run(0, 1'b0, "R1");
        expect_run(2, 1'b0, "R1");
        expect_run(3, 1'b1, "R1");

        // R2, R9: single-cycle conv_uv pulse; R3: full timeout; R7: pulse mid-timeout
        expect_run(12, 1'b1, "R2");
        expect_run(13, 1'b0, "R9");
        expect_run(22, 1'b0, "R7");
        expect_run(28, 1'b0, "R3");
        expect_run(29, 1'b0, "R3");
        expect_run(30, 1'b1, "R7");
        wait_cyc(10); conv_uv = 1'b1;
        wait_cyc(11); conv_uv = 1'b0;
        wait_cyc(18); over_temp = 1'b1;
        wait_cyc(19); over_temp = 1'b0;

        // R4: persistent bias undervoltage holds idle after the timeout
        expect_run(42, 1'b1, "R2");
        expect_run(43, 1'b0, "R2");
        expect_run(70, 1'b0, "R4");
        expect_run(82, 1'b0, "R4");
        expect_run(83, 1'b1, "R4");
        wait_cyc(40); bias_uv = 1'b1;
        wait_cyc(80); bias_uv = 1'b0;

        // R6: reference not ready holds idle
        expect_run(93, 1'b0, "R6");
        expect_run(120, 1'b0, "R6");
        expect_run(127, 1'b0, "R6");
        expect_run(128, 1'b1, "R6");
        wait_cyc(90); over_temp = 1'b1; ref_ready = 1'b0;
        wait_cyc(95); over_temp = 1'b0;
        wait_cyc(125); ref_ready = 1'b1;

        // R5: persistent short gives one-cycle retries every T+2 clocks
        expect_run(142, 1'b1, "R5");
        expect_run(143, 1'b0, "R5");
        expect_run(159, 1'b0, "R5");
        expect_run(160, 1'b1, "R5");
        expect_run(161, 1'b0, "R5");
        expect_run(177, 1'b0, "R5");
        expect_run(178, 1'b1, "R5");
        expect_run(179, 1'b0, "R5");
        expect_run(195, 1'b0, "R5");
        expect_run(196, 1'b1, "R5");
        expect_run(205, 1'b1, "R5");
        wait_cyc(140); short_f = 1'b1;
        wait_cyc(185); short_f = 1'b0;

        wait_cyc(210);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending=%0d expected=0", q.size());
        end
        report();
    end

endmodule